// File: doc/BRIEF.md
# Synchronous Three-Wire Memory Card Front End

This block sits between a host's three card signals and the storage of a byte-addressed memory card of 1024 bytes, each byte carrying one extra protect bit. A control line selects the role of the shared data line. While it is high, the host shifts a 24-bit command into the block. While it is low, the block streams stored bits back. All card signals are taken in through synchronizers and sampled on a fast system clock. The card clock and the control line are treated as slow events that the block detects by their edges.

The block keeps a 10-bit address counter. It performs the answer-to-reset, which returns the counter to zero and presents the first stored bit. It decodes three-byte commands. It runs two read modes: a plain byte stream and a byte-plus-protect-bit stream. Both advance the address on their own. Write, erase and verification commands do no work here. They are handed to a separate programming sequencer as a one-cycle request, and only once a read has completed since power-up. The storage array sits outside the block behind a combinational read port.

Top module: `sync_card_front`

## Requirements
- R1: A rising edge of `card_ctl` aborts any read stream in progress. From then on the block releases the data line (`io_pull_low` = 0).
- R2: An answer-to-reset is `card_ctl` high, exactly one `card_clk` pulse, then `card_ctl` low. It loads address 0 and presents bit 0 of that byte on the data line as soon as `card_ctl` is low.
- R3: While `card_ctl` is high, the block never drives the data line. The line is then an input only.
- R4: A command counts only when exactly 24 `card_clk` rising edges occur while `card_ctl` is high. Each bit is sampled from `io_in` on a rising edge, least significant first. Bits 0..5 form the control code, bits 6 and 7 are address bits 8 and 9, bits 8..15 are address bits 0..7, and bits 16..23 are the data byte. Any other count of clock edges does nothing.
- R5: Control code 0x0E starts a byte read at the command address. The data line shows D0 once `card_ctl` is low. Each `card_clk` falling edge moves to the next bit. After the eighth falling edge the address is incremented and D0 of the next byte follows.
- R6: Control code 0x0C starts a nine-bit read. D0..D7 are followed by the protect bit, and the address is incremented after the ninth falling edge.
- R7: The data line is open-drain with an external pull-up. `io_pull_low` is 1 exactly when a read is active, `card_ctl` is low and the current bit is 0.
- R8: After reset of the block, no write request is issued until one full byte has been read out in any read mode, including answer-to-reset.
- R9: Once reads are unlocked, a write code produces one `req_valid` pulse carrying the operation, the command address and the data byte. The codes map as follows: 0x33 gives op 0 (write/erase), 0x31 gives op 1 (write/erase with protect), 0x30 gives op 2 (set protect after compare), 0x32 gives op 3 (error counter), and 0x0D gives op 4 (verify). Any other code produces no request and stops the read stream.
- R10: The address counter wraps from 1023 to 0.
- R11: After reset of the block, `mem_addr` is 0, `io_pull_low` is 0 and `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| card_ctl | input | 1 | Card control line: high = command entry, low = data output |
| card_clk | input | 1 | Card clock |
| io_in | input | 1 | Level seen on the shared data line |
| io_pull_low | output | 1 | 1 pulls the open-drain data line low |
| mem_addr | output | 10 | Address of the byte being read |
| mem_data | input | 8 | Stored byte at `mem_addr` |
| mem_prot | input | 1 | Stored protect bit at `mem_addr` |
| req_valid | output | 1 | One-cycle request to the programming sequencer |
| req_op | output | 3 | Requested operation (see R9) |
| req_addr | output | 10 | Address field of the request |
| req_data | output | 8 | Data byte of the request |

## Verification
Reads run against a storage model whose bytes and protect bits vary with the address. A stuck bit index, a swapped bit order or a wrong increment point therefore shows up as a wrong level on the line. A plain read that starts near the top of the address space crosses the wrap point. A nine-bit read separates the protect bit from the next byte's D0. A write command sent before any read, and again after one, tells the lock apart from a broken decode. A short clock burst, an unknown code and a read cut short by a control rise check that malformed or aborted traffic leaves the outputs quiet.

// File: rtl/sc_pkg.sv
package sc_pkg;
   typedef enum logic [1:0] {
      RM_IDLE    = 2'd0,
      RM_BYTE    = 2'd1,
      RM_BYTE_PB = 2'd2
   } rmode_t;

   localparam int CTRL_W = 6;

   localparam logic [CTRL_W-1:0] C_READ8  = 6'h0E;
   localparam logic [CTRL_W-1:0] C_READ9  = 6'h0C;
   localparam logic [CTRL_W-1:0] C_WE     = 6'h33;
   localparam logic [CTRL_W-1:0] C_WE_PB  = 6'h31;
   localparam logic [CTRL_W-1:0] C_PB_CMP = 6'h30;
   localparam logic [CTRL_W-1:0] C_ERRCNT = 6'h32;
   localparam logic [CTRL_W-1:0] C_VERIFY = 6'h0D;

   typedef enum logic [2:0] {
      OP_WE     = 3'd0,
      OP_WE_PB  = 3'd1,
      OP_PB_CMP = 3'd2,
      OP_ERRCNT = 3'd3,
      OP_VERIFY = 3'd4
   } req_op_t;
endpackage

// File: rtl/sc_edge.sv
module sc_edge #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 1) begin : g_bad
         $error("sc_edge: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= INIT;
            else        chain <= d;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= {STAGES{INIT}};
            else        chain <= {chain[STAGES-2:0], d};
      end
   endgenerate

   assign lvl = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= INIT;
      else        prev <= lvl;

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/sc_cmd.sv
module sc_cmd #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_lvl,
   input  logic              ctl_rise,
   input  logic              ctl_fall,
   input  logic              sclk_rise,
   input  logic              io_bit,
   output logic              atr,
   output logic              cmd_valid,
   output logic [5:0]        cmd_ctrl,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data
);
   localparam int CTRL_W = sc_pkg::CTRL_W;
   localparam int HI_W   = ADDR_W - DATA_W;
   localparam int CMD_W  = 3 * DATA_W;
   localparam int CNT_W  = $clog2(CMD_W + 2);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CMD_W + 1);

   generate
      if (CTRL_W + HI_W != DATA_W) begin : g_bad
         $error("sc_cmd: control bits plus high address bits must fill one byte");
      end
   endgenerate

   logic [CMD_W-1:0] sr;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         cnt <= '0;
      end else if (ctl_rise) begin
         cnt <= '0;
      end else if (ctl_lvl && sclk_rise) begin
         sr <= {io_bit, sr[CMD_W-1:1]};
         if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
   end

   assign atr       = ctl_fall && (cnt == CNT_W'(1));
   assign cmd_valid = ctl_fall && (cnt == CNT_W'(CMD_W));
   assign cmd_ctrl  = sr[CTRL_W-1:0];
   assign cmd_addr  = {sr[DATA_W-1:CTRL_W], sr[2*DATA_W-1:DATA_W]};
   assign cmd_data  = sr[CMD_W-1:2*DATA_W];

   assert_count_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rise |=> (cnt == '0));
   assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);
endmodule

// File: rtl/sc_rdpath.sv
module sc_rdpath #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_lvl,
   input  logic              ctl_rise,
   input  logic              sclk_fall,
   input  logic              atr,
   input  logic              cmd_valid,
   input  logic [5:0]        cmd_ctrl,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] mem_data,
   input  logic              mem_prot,
   output logic [ADDR_W-1:0] addr,
   output logic              io_pull_low,
   output logic              unlocked
);
   import sc_pkg::*;

   localparam int BIDX_W = $clog2(DATA_W + 1);
   localparam int SEL_W  = $clog2(DATA_W);
   localparam logic [BIDX_W-1:0] LAST_D  = BIDX_W'(DATA_W - 1);
   localparam logic [BIDX_W-1:0] LAST_PB = BIDX_W'(DATA_W);

   rmode_t            mode;
   logic [BIDX_W-1:0] bidx;
   logic              cur_bit;
   logic              step;
   logic              byte_end;

   assign step     = sclk_fall && !ctl_lvl && (mode != RM_IDLE);
   assign byte_end = (mode == RM_BYTE_PB) ? (bidx == LAST_PB) : (bidx == LAST_D);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= RM_IDLE;
         bidx     <= '0;
         addr     <= '0;
         unlocked <= 1'b0;
      end else if (ctl_rise) begin
         mode <= RM_IDLE;
      end else if (atr) begin
         addr <= '0;
         bidx <= '0;
         mode <= RM_BYTE;
      end else if (cmd_valid) begin
         bidx <= '0;
         if (cmd_ctrl == C_READ8) begin
            addr <= cmd_addr;
            mode <= RM_BYTE;
         end else if (cmd_ctrl == C_READ9) begin
            addr <= cmd_addr;
            mode <= RM_BYTE_PB;
         end else begin
            mode <= RM_IDLE;
         end
      end else if (step) begin
         if (byte_end) begin
            bidx     <= '0;
            addr     <= addr + 1'b1;
            unlocked <= 1'b1;
         end else begin
            bidx <= bidx + 1'b1;
         end
      end
   end

   assign cur_bit     = (bidx < BIDX_W'(DATA_W)) ? mem_data[bidx[SEL_W-1:0]] : mem_prot;
   assign io_pull_low = (mode != RM_IDLE) && !ctl_lvl && !cur_bit;

   assert_abort_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rise |=> (mode == RM_IDLE));
   assert_atr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      atr |=> (addr == '0) && (bidx == '0));
   assert_byte_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && byte_end && !ctl_rise && !atr && !cmd_valid)
      |=> (addr == $past(addr) + 1'b1) && unlocked);
   assert_bidx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bidx <= LAST_PB);
   assert_unlock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(unlocked) |-> unlocked);
endmodule

// File: rtl/sync_card_front.sv
module sync_card_front #(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              card_ctl,
   input  logic              card_clk,
   input  logic              io_in,
   output logic              io_pull_low,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_data,
   input  logic              mem_prot,
   output logic              req_valid,
   output logic [2:0]        req_op,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data
);
   import sc_pkg::*;

   logic ctl_lvl, ctl_rise, ctl_fall;
   logic sclk_lvl, sclk_rise, sclk_fall;
   logic io_lvl, io_rise_nc, io_fall_nc;
   logic atr, cmd_valid, unlocked;
   logic [5:0]        cmd_ctrl;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_data;
   logic              wr_hit;
   req_op_t           wr_op;

   sc_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_ctl (
      .clk(clk), .rst_n(rst_n), .d(card_ctl),
      .lvl(ctl_lvl), .rise(ctl_rise), .fall(ctl_fall));
   sc_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sclk (
      .clk(clk), .rst_n(rst_n), .d(card_clk),
      .lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));
   sc_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_io (
      .clk(clk), .rst_n(rst_n), .d(io_in),
      .lvl(io_lvl), .rise(io_rise_nc), .fall(io_fall_nc));

   sc_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .ctl_lvl(ctl_lvl), .ctl_rise(ctl_rise),
      .ctl_fall(ctl_fall), .sclk_rise(sclk_rise), .io_bit(io_lvl),
      .atr(atr), .cmd_valid(cmd_valid), .cmd_ctrl(cmd_ctrl),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data));

   sc_rdpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .ctl_lvl(ctl_lvl), .ctl_rise(ctl_rise),
      .sclk_fall(sclk_fall), .atr(atr), .cmd_valid(cmd_valid),
      .cmd_ctrl(cmd_ctrl), .cmd_addr(cmd_addr), .mem_data(mem_data),
      .mem_prot(mem_prot), .addr(mem_addr), .io_pull_low(io_pull_low),
      .unlocked(unlocked));

   always_comb begin
      wr_hit = 1'b1;
      wr_op  = OP_WE;
      case (cmd_ctrl)
         C_WE:     wr_op = OP_WE;
         C_WE_PB:  wr_op = OP_WE_PB;
         C_PB_CMP: wr_op = OP_PB_CMP;
         C_ERRCNT: wr_op = OP_ERRCNT;
         C_VERIFY: wr_op = OP_VERIFY;
         default:  wr_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_op    <= '0;
         req_addr  <= '0;
         req_data  <= '0;
      end else begin
         req_valid <= cmd_valid && wr_hit && unlocked;
         if (cmd_valid && wr_hit && unlocked) begin
            req_op   <= wr_op;
            req_addr <= cmd_addr;
            req_data <= cmd_data;
         end
      end
   end

   assert_req_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> unlocked);
   assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);
   assert_line_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(card_ctl) && card_ctl && sclk_lvl) |-> !io_pull_low);
endmodule

// File: tb/sim_sync_card_front.sv
module sim_sync_card_front;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       card_ctl = 1'b0;
   logic       card_clk = 1'b0;
   logic       io_in = 1'b1;
   logic       io_pull_low;
   logic [9:0] mem_addr;
   logic [7:0] mem_data;
   logic       mem_prot;
   logic       req_valid;
   logic [2:0] req_op;
   logic [9:0] req_addr;
   logic [7:0] req_data;

   int n_checks = 0;
   int n_fail   = 0;
   int n_req    = 0;
   logic [2:0] last_op;
   logic [9:0] last_addr;
   logic [7:0] last_data;
   bit finished = 0;

   always #4 clk = ~clk;

   function automatic logic [7:0] byte_at(input logic [9:0] a);
      logic [15:0] t;
      t = 16'(a) * 16'd37 + 16'd11;
      return t[7:0] ^ {6'd0, a[9:8]};
   endfunction
   function automatic logic prot_at(input logic [9:0] a);
      return a[0] ^ a[2];
   endfunction

   assign mem_data = byte_at(mem_addr);
   assign mem_prot = prot_at(mem_addr);

   sync_card_front u0 (
      .clk(clk), .rst_n(rst_n), .card_ctl(card_ctl), .card_clk(card_clk),
      .io_in(io_in), .io_pull_low(io_pull_low), .mem_addr(mem_addr),
      .mem_data(mem_data), .mem_prot(mem_prot), .req_valid(req_valid),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data));

   always @(posedge clk) begin
      if (rst_n && req_valid) begin
         n_req     <= n_req + 1;
         last_op   <= req_op;
         last_addr <= req_addr;
         last_data <= req_data;
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic pulse();
      card_clk = 1'b1; settle();
      card_clk = 1'b0; settle();
   endtask

   task automatic do_atr();
      card_ctl = 1'b1; settle();
      pulse();
      card_ctl = 1'b0; settle();
   endtask

   task automatic send(input logic [5:0] code, input logic [9:0] a,
                       input logic [7:0] d, input int nclk);
      logic [23:0] w;
      w = {d, a[7:0], a[9:8], code};
      card_ctl = 1'b1; settle();
      for (int i = 0; i < nclk; i++) begin
         io_in = w[i % 24];
         pulse();
      end
      io_in = 1'b1;
      card_ctl = 1'b0; settle();
   endtask

   // Reads nbits from the line; per_byte is 8 or 9.
   task automatic read_stream(input string req, input logic [9:0] start,
                              input int per_byte, input int nbits);
      logic [9:0] a;
      a = start;
      for (int i = 0; i < nbits; i++) begin
         int k;
         logic exp_bit;
         k = i % per_byte;
         exp_bit = (k < 8) ? byte_at(a)[k] : prot_at(a);
         check(req, io_pull_low, !exp_bit);
         pulse();
         if (k == per_byte - 1) a = a + 10'd1;
      end
      check(req, mem_addr, a);
   endtask

   task automatic t_reset();
      check("R11 pull", io_pull_low, 0);
      check("R11 addr", mem_addr, 0);
      check("R11 req", req_valid, 0);
   endtask

   task automatic t_locked_write();
      send(6'h33, 10'd40, 8'h5A, 24);
      settle();
      check("R8 no request before read", n_req, 0);
      check("R8 line released", io_pull_low, 0);
   endtask

   task automatic t_atr();
      do_atr();
      check("R2 addr zero", mem_addr, 0);
      read_stream("R2 stream", 10'd0, 8, 16);
   endtask

   task automatic t_read8_wrap();
      send(6'h0E, 10'd1021, 8'h00, 24);
      check("R5 start addr", mem_addr, 1021);
      read_stream("R5/R10 wrap read", 10'd1021, 8, 32);
      check("R10 wrapped", mem_addr, 1);
   endtask

   task automatic t_read9();
      send(6'h0C, 10'd5, 8'h00, 24);
      read_stream("R6 nine-bit read", 10'd5, 9, 27);
      check("R6 addr after three", mem_addr, 8);
   endtask

   task automatic t_ctl_high_quiet();
      send(6'h0E, 10'd2, 8'h00, 24);
      card_ctl = 1'b1; settle();
      check("R3 line input while ctl high", io_pull_low, 0);
      pulse();
      check("R3 still released", io_pull_low, 0);
      card_ctl = 1'b0; settle();
   endtask

   task automatic t_writes();
      int base;
      base = n_req;
      send(6'h31, 10'd777, 8'hC3, 24);
      settle();
      check("R9 one request", n_req, base + 1);
      check("R9 op", last_op, 1);
      check("R9 addr", last_addr, 777);
      check("R9 data", last_data, 8'hC3);
      send(6'h0D, 10'd1022, 8'h3C, 24);
      settle();
      check("R9 verify op", last_op, 4);
      check("R9 verify addr", last_addr, 1022);
      send(6'h30, 10'd3, 8'h81, 24);
      settle();
      check("R9 compare op", last_op, 2);
      send(6'h32, 10'd1021, 8'hFE, 24);
      settle();
      check("R9 counter op", last_op, 3);
      check("R9 count", n_req, base + 4);
      send(6'h15, 10'd9, 8'h00, 24);
      settle();
      check("R9 unknown code no request", n_req, base + 4);
      check("R9 unknown code line idle", io_pull_low, 0);
      pulse();
      check("R9 unknown code still idle", io_pull_low, 0);
   endtask

   task automatic t_short_burst();
      int base;
      base = n_req;
      send(6'h33, 10'd12, 8'h00, 10);
      settle();
      check("R4 short burst no request", n_req, base);
      check("R4 short burst line idle", io_pull_low, 0);
      send(6'h33, 10'd12, 8'h00, 25);
      settle();
      check("R4 long burst no request", n_req, base);
   endtask

   task automatic t_abort();
      logic [9:0] a0;
      send(6'h0C, 10'd300, 8'h00, 24);
      pulse(); pulse(); pulse();
      a0 = mem_addr;
      check("R1 mid-read addr", a0, 300);
      card_ctl = 1'b1; settle();
      check("R1 released on ctl rise", io_pull_low, 0);
      card_ctl = 1'b0; settle();
      check("R1 no stream after abort", io_pull_low, 0);
      pulse();
      check("R1 addr unchanged after abort", mem_addr, 300);
      do_atr();
      check("R1/R2 atr after abort", mem_addr, 0);
      check("R7 atr first bit", io_pull_low, !byte_at(10'd0)[0]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_locked_write();
      t_atr();
      t_read8_wrap();
      t_read9();
      t_ctl_high_quiet();
      t_writes();
      t_short_burst();
      t_abort();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule